// File: doc/BRIEF.md
# Sector Erase Accumulation Timer

This block collects sector erase requests into a selection bitmap and holds them in an open acceptance window before committing to the erase. The first sector request starts a countdown; every further sector request that arrives while the countdown is running marks its sector and restarts the full countdown. When the countdown runs out, the window status output goes high and the committed erase phase begins. From then on every sector or chip request is ignored until the erase completes.

The length of the erase is modelled by a counter loaded with the number of selected sectors times a per-sector cycle count. A suspend request pauses that counter and raises a suspended flag, and a resume request lets it continue. A chip erase request from the idle state selects every sector and goes straight to the committed phase without opening a window. When the counter finishes, a one-cycle done pulse is raised, the bitmap is cleared and the window status returns to 0. Command sequence decoding and the array clearing itself are handled elsewhere.

Top module: `sector_erase_window`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, sel_map is all zeros and win_closed, busy, suspended and done are 0.
- R2: A sec_cmd pulse in the idle state sets bit sec_addr of sel_map, raises busy and leaves win_closed at 0, all visible after the next clock edge.
- R3: win_closed rises exactly WIN_CYC clock edges after the edge that accepted the most recent sector command. Every sector command accepted while the window is open restarts this full count.
- R4: A sector command for a sector already set in sel_map leaves sel_map unchanged and only restarts the window count.
- R5: A sec_cmd present in the cycle whose closing edge raises win_closed is not accepted and does not set its bit in sel_map.
- R6: While win_closed is 1, sec_cmd and chip_cmd have no effect: sel_map does not change until done.
- R7: With no suspension, done pulses for one cycle exactly popcount(sel_map) * ERASE_CYC edges after the edge that raised win_closed. In that same cycle sel_map is zero and win_closed and busy are 0.
- R8: A chip_cmd in the idle state sets every bit of sel_map and raises win_closed at the next edge without any window. The erase then lasts N_SECT * ERASE_CYC edges. chip_cmd takes priority over a simultaneous sec_cmd.
- R9: suspend during the committed phase sets suspended and freezes the erase count. resume clears suspended and counting continues, so every edge from suspend through resume inclusive adds one edge to the erase length.
- R10: suspend and resume have no effect outside the committed phase, and chip_cmd has no effect while the window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_cmd | input | 1 | One-cycle sector erase request |
| sec_addr | input | SW | Sector index of the request |
| chip_cmd | input | 1 | One-cycle whole-array erase request |
| suspend | input | 1 | Pause the running erase |
| resume | input | 1 | Continue a paused erase |
| sel_map | output | N_SECT | Bitmap of sectors queued for erase |
| win_closed | output | 1 | 0 while the window accepts sectors, 1 once the erase is committed |
| busy | output | 1 | Window open or erase in progress |
| suspended | output | 1 | Erase paused |
| done | output | 1 | One-cycle pulse at erase completion |

## Verification
The assertions assume that the request inputs are single-cycle, synchronous pulses and that sec_addr is below N_SECT whenever sec_cmd is high. They also assume that suspend and resume may be asserted in any state, since the block must filter them itself. The stimulus stays within these limits: it drives requests only at the falling edge and draws sector indices modulo N_SECT. It raises sec_cmd, chip_cmd, suspend and resume at independent random rates, so every combination reaches every state, including the closing edge of the window.

// File: rtl/sector_erase_window.sv
module sector_erase_window #(
  parameter int N_SECT    = 16,
  parameter int WIN_CYC   = 12,
  parameter int ERASE_CYC = 4,
  localparam int SW  = (N_SECT > 1) ? $clog2(N_SECT) : 1,
  localparam int WCW = $clog2(WIN_CYC + 1),
  localparam int ECW = $clog2(N_SECT * ERASE_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_cmd,
  input  logic [SW-1:0]     sec_addr,
  input  logic              chip_cmd,
  input  logic              suspend,
  input  logic              resume,
  output logic [N_SECT-1:0] sel_map,
  output logic              win_closed,
  output logic              busy,
  output logic              suspended,
  output logic              done
);

  typedef enum logic [1:0] {S_IDLE, S_WIN, S_ERASE} st_t;

  st_t            st;
  logic [WCW-1:0] wcnt;
  logic [ECW-1:0] ecnt;

  function automatic int count_set(input logic [N_SECT-1:0] m);
    int c = 0;
    for (int i = 0; i < N_SECT; i++) c += int'(m[i]);
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      wcnt      <= '0;
      ecnt      <= '0;
      sel_map   <= '0;
      suspended <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (chip_cmd) begin
            sel_map <= '1;
            ecnt    <= ECW'(N_SECT * ERASE_CYC);
            st      <= S_ERASE;
          end else if (sec_cmd) begin
            sel_map[sec_addr] <= 1'b1;
            wcnt              <= WCW'(WIN_CYC - 1);
            st                <= S_WIN;
          end
        end
        S_WIN: begin
          if (wcnt == '0) begin
            ecnt <= ECW'(count_set(sel_map) * ERASE_CYC);
            st   <= S_ERASE;
          end else if (sec_cmd) begin
            sel_map[sec_addr] <= 1'b1;
            wcnt              <= WCW'(WIN_CYC - 1);
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        default: begin
          if (suspended) begin
            if (resume) suspended <= 1'b0;
          end else if (suspend) begin
            suspended <= 1'b1;
          end else if (ecnt == ECW'(1)) begin
            done    <= 1'b1;
            sel_map <= '0;
            st      <= S_IDLE;
          end else begin
            ecnt <= ecnt - 1'b1;
          end
        end
      endcase
    end
  end

  assign win_closed = (st == S_ERASE);
  assign busy       = (st != S_IDLE);

  a_r2_idle_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && sec_cmd && !chip_cmd) |=> (busy && !win_closed && sel_map[$past(sec_addr)]));

  a_r3_window_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !win_closed && sec_cmd && wcnt != '0) |=> (!win_closed && sel_map[$past(sec_addr)]));

  a_r6_map_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (win_closed && !done) |=> (done || sel_map == $past(sel_map)));

  a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sel_map == '0 && !busy && !win_closed));

  a_r7_done_after_erase: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(win_closed));

  a_r8_chip_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && chip_cmd) |=> (win_closed && (&sel_map)));

  a_r9_susp_in_erase: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> win_closed);

  a_r9_susp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !resume) |=> (suspended && !done && $stable(ecnt)));

endmodule

// File: tb/tb_sector_erase_window.sv
module tb_sector_erase_window;
  localparam int N  = 16;
  localparam int W  = 12;
  localparam int E  = 4;
  localparam int SW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_cmd = 1'b0, chip_cmd = 1'b0, suspend = 1'b0, resume = 1'b0;
  logic [SW-1:0] sec_addr = '0;
  logic [N-1:0] sel_map;
  logic win_closed, busy, suspended, done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sector_erase_window #(.N_SECT(N), .WIN_CYC(W), .ERASE_CYC(E)) dut (
    .clk(clk), .rst_n(rst_n), .sec_cmd(sec_cmd), .sec_addr(sec_addr),
    .chip_cmd(chip_cmd), .suspend(suspend), .resume(resume),
    .sel_map(sel_map), .win_closed(win_closed), .busy(busy),
    .suspended(suspended), .done(done));

  // reference model built from the requirements
  int           m_st = 0;
  int           m_w = 0;
  int           m_e = 0;
  logic [N-1:0] m_map = '0;
  logic         m_susp = 1'b0;
  logic         m_done = 1'b0;

  function automatic int ones(input logic [N-1:0] m);
    int c = 0;
    for (int i = 0; i < N; i++) if (m[i]) c++;
    return c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_w = 0; m_e = 0; m_map = '0; m_susp = 1'b0; m_done = 1'b0;
    end else begin
      m_done = 1'b0;
      if (m_st == 0) begin
        if (chip_cmd) begin m_map = '1; m_e = N * E; m_st = 2; end
        else if (sec_cmd) begin m_map[sec_addr] = 1'b1; m_w = W; m_st = 1; end
      end else if (m_st == 1) begin
        m_w--;
        if (m_w == 0) begin m_e = ones(m_map) * E; m_st = 2; end
        else if (sec_cmd) begin m_map[sec_addr] = 1'b1; m_w = W; end
      end else begin
        if (m_susp) begin if (resume) m_susp = 1'b0; end
        else if (suspend) m_susp = 1'b1;
        else begin
          m_e--;
          if (m_e == 0) begin m_done = 1'b1; m_map = '0; m_st = 0; end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R2 sel_map", 64'(sel_map), 64'(m_map));
    chk("R3 win_closed", 64'(win_closed), 64'(m_st == 2));
    chk("R7 busy", 64'(busy), 64'(m_st != 0));
    chk("R7 done", 64'(done), 64'(m_done));
    chk("R9 suspended", 64'(suspended), 64'(m_susp));
  endtask

  task automatic step(input logic s, input int a, input logic c, input logic sp, input logic rs);
    sec_cmd = s; sec_addr = SW'(a); chip_cmd = c; suspend = sp; resume = rs;
    @(posedge clk);
    @(negedge clk);
    compare();
    sec_cmd = 1'b0; chip_cmd = 1'b0; suspend = 1'b0; resume = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && busy; i++) idle(1);
  endtask

  initial begin
    int len;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 map in reset", 64'(sel_map), 64'd0);
    chk("R1 flags in reset", 64'({win_closed, busy, suspended, done}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 map after reset", 64'(sel_map), 64'd0);

    // R2 / R4 / R3 / R5
    step(1'b1, 5, 1'b0, 1'b0, 1'b0);
    chk("R2 first sector", 64'({sel_map, busy, win_closed}), 64'({16'h0020, 1'b1, 1'b0}));
    idle(3);
    step(1'b1, 5, 1'b0, 1'b0, 1'b0);
    chk("R4 repeat sector", 64'(sel_map), 64'h0020);
    idle(W - 1);
    chk("R3 still open", 64'(win_closed), 64'd0);
    step(1'b1, 6, 1'b0, 1'b0, 1'b0);
    chk("R3 window closed", 64'(win_closed), 64'd1);
    chk("R5 late sector dropped", 64'(sel_map), 64'h0020);

    // R6 ignored during erase, R9 suspend
    step(1'b1, 9, 1'b0, 1'b0, 1'b0);
    step(1'b0, 0, 1'b1, 1'b0, 1'b0);
    chk("R6 map frozen", 64'(sel_map), 64'h0020);
    step(1'b0, 0, 1'b0, 1'b1, 1'b0);
    chk("R9 suspended set", 64'(suspended), 64'd1);
    idle(20);
    chk("R9 no done while paused", 64'({suspended, done, win_closed}), 64'b101);
    step(1'b0, 0, 1'b0, 1'b0, 1'b1);
    chk("R9 resumed", 64'(suspended), 64'd0);
    drain();

    // R7 exact length, two sectors
    step(1'b1, 1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 14, 1'b0, 1'b0, 1'b0);
    idle(W);
    chk("R7 committed", 64'({win_closed, sel_map}), 64'({1'b1, 16'h4002}));
    len = 0;
    while (!done && len < 200) begin idle(1); len++; end
    chk("R7 erase length", 64'(len), 64'(2 * E));
    chk("R7 cleared at done", 64'({sel_map, busy}), 64'd0);

    // R10 suspend in idle, chip in window
    step(1'b0, 0, 1'b0, 1'b1, 1'b0);
    chk("R10 suspend in idle", 64'({suspended, busy}), 64'd0);
    step(1'b1, 2, 1'b0, 1'b0, 1'b0);
    step(1'b0, 0, 1'b1, 1'b1, 1'b0);
    chk("R10 chip in window", 64'({sel_map, win_closed, suspended}), 64'({16'h0004, 1'b0, 1'b0}));
    drain();

    // R8 chip erase with simultaneous sector request
    step(1'b1, 3, 1'b1, 1'b0, 1'b0);
    chk("R8 chip map", 64'({sel_map, win_closed}), 64'({16'hFFFF, 1'b1}));
    len = 0;
    while (!done && len < 200) begin idle(1); len++; end
    chk("R8 chip length", 64'(len), 64'(N * E));

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 4) == 0, int'($urandom % N), ($urandom % 40) == 0,
           ($urandom % 20) == 0, ($urandom % 6) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule